// File: doc/BRIEF.md
# Interval Timer with Register Interface

This block is a 32-bit down-counter that raises a timeout after a programmed number of counter ticks. Software reaches it through a small word-indexed register bus: six registers hold the status flags, the control bits, the two 16-bit halves of the period and the two halves of a captured count. The counter moves only on cycles where `tick_en` is high, so a prescaler elsewhere sets the time base.

Software writes the period, then sets the start command and chooses one-shot or continuous reload. A timeout sets a sticky flag, which stays set until software writes the status register. The live count cannot be read directly. Software first writes either capture register, which freezes the count, and then reads the two halves back. The interrupt line is a level that stays high while the timeout flag and the interrupt enable are both set.

Top module: `intv_timer`

## Requirements
- R1: After reset, every register reads zero, the timer is stopped and the counter holds 0xFFFFFFFF. A capture taken right after reset therefore reads 0xFFFF in both halves.
- R2: The register index is the byte address shifted right by two, and the two low address bits are ignored. The indices are: 0 status, 1 control, 2 period low, 3 period high, 4 capture low, 5 capture high. An index of 6 or above reads zero, and a write to it changes nothing.
- R3: Control bit 0 is the interrupt enable and bit 1 selects continuous mode. Both bits are stored from every control write. Bit 2 (start) and bit 3 (stop) are commands. They are not stored, so reading control returns only bits 1:0 and zeros above them.
- R4: A start command runs a stopped timer, and a stop command halts a running one. A start sent while the timer runs, or a stop sent while it is stopped, does nothing. When start and stop come in the same write, the timer ends up stopped.
- R5: Each period register keeps only data bits 15:0. A write to either period half stops the timer, clears the running flag (status bit 1) and loads the counter with {high, low}.
- R6: A running timer started with the counter at P sets the timeout flag (status bit 0) on the (P+1)-th cycle with `tick_en` high. Cycles with `tick_en` low do not count.
- R7: On timeout the counter reloads with the period value. In continuous mode the timer keeps running. In one-shot mode it stops and the running flag clears.
- R8: A write to either capture register copies the counter at once: bits 15:0 go to capture low and bits 31:16 go to capture high. Reads return the last captured value.
- R9: Any write to status clears the timeout flag, whatever the data. If a timeout happens in the same cycle, the flag is set instead.
- R10: `irq` is high exactly while the timeout flag and the interrupt enable are both set.
- R11: The running flag cannot be written. A status write leaves it unchanged.
- R12: A read strobe returns the selected register on `rd_data` one cycle later, with `rd_valid` high for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advances on cycles where this is high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte address |
| wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | DATA_W (32) | Read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench counts the exact ticks to a timeout with period 3, so it catches a design that fires one tick early or one tick late, or that counts while `tick_en` is low. It sends start and stop in one write to a stopped timer; a design that checks stop before start would leave the timer running. It writes a period while the timer runs, and a design that keeps running after that write shows a set running flag. It also lines up a status write and a zero-period timeout in the same cycle; a design that gives the clear priority would drop that event.

// File: rtl/intv_timer_pkg.sv
`timescale 1ns/1ps
package intv_timer_pkg;
  // register indices (byte address >> 2)
  localparam int unsigned IX_STATUS = 0;
  localparam int unsigned IX_CTRL   = 1;
  localparam int unsigned IX_PER_LO = 2;
  localparam int unsigned IX_PER_HI = 3;
  localparam int unsigned IX_CAP_LO = 4;
  localparam int unsigned IX_CAP_HI = 5;
  localparam int unsigned NUM_REGS  = 6;

  // status bit positions
  localparam int unsigned ST_TO  = 0;
  localparam int unsigned ST_RUN = 1;

  // control bit positions
  localparam int unsigned CT_IEN  = 0;
  localparam int unsigned CT_CONT = 1;
  localparam int unsigned CT_GO   = 2;
  localparam int unsigned CT_HALT = 3;

  typedef struct packed {
    logic cont;
    logic ien;
  } ctrl_t;
endpackage

// File: rtl/intv_counter.sv
`timescale 1ns/1ps
module intv_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic             step, cnt_ce;

  always_comb begin
    step   = run & tick_en;
    expire = step & (cnt_q == '0);
    cnt_ce = load | step;
    lim_d  = load ? load_val : lim_q;
    if (load)        cnt_d = load_val;
    else if (expire) cnt_d = lim_q;
    else             cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      lim_q <= '1;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      if (load)   lim_q <= lim_d;
    end
  end

  assign count = cnt_q;

  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && !load && cnt_q == '0) |=> (cnt_q == lim_q));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(run && tick_en)) |=> $stable(cnt_q));
endmodule

// File: rtl/intv_regfile.sv
`timescale 1ns/1ps
module intv_regfile
  import intv_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   count,
  input  logic                expire,
  output logic                run,
  output logic                to_flag,
  output ctrl_t               ctrl,
  output logic [DATA_W/2-1:0] per_lo,
  output logic [DATA_W/2-1:0] per_hi,
  output logic                per_load,
  output logic [DATA_W-1:0]   per_val,
  output logic [DATA_W-1:0]   cap
);
  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              hit_st, hit_ct, hit_plo, hit_phi, hit_cap;
  logic              run_q, run_d, to_q, to_d, cmd_run;
  ctrl_t             ctrl_q, ctrl_d;
  logic [HALF_W-1:0] plo_q, plo_d, phi_q, phi_d;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic              unused_wr;

  assign idx       = addr[ADDR_W-1:2];
  assign unused_wr = ^{addr[1:0], wdata[DATA_W-1:HALF_W]};

  always_comb begin
    hit_st  = wr_en && (idx == IDX_W'(IX_STATUS));
    hit_ct  = wr_en && (idx == IDX_W'(IX_CTRL));
    hit_plo = wr_en && (idx == IDX_W'(IX_PER_LO));
    hit_phi = wr_en && (idx == IDX_W'(IX_PER_HI));
    hit_cap = wr_en && ((idx == IDX_W'(IX_CAP_LO)) || (idx == IDX_W'(IX_CAP_HI)));

    plo_d    = hit_plo ? wdata[HALF_W-1:0] : plo_q;
    phi_d    = hit_phi ? wdata[HALF_W-1:0] : phi_q;
    per_load = hit_plo | hit_phi;
    per_val  = {phi_d, plo_d};

    ctrl_d = ctrl_q;
    if (hit_ct) begin
      ctrl_d.ien  = wdata[CT_IEN];
      ctrl_d.cont = wdata[CT_CONT];
    end

    // start evaluated first, then stop
    cmd_run = run_q;
    if (wdata[CT_GO] && !cmd_run)  cmd_run = 1'b1;
    if (wdata[CT_HALT] && cmd_run) cmd_run = 1'b0;

    if (per_load)                   run_d = 1'b0;
    else if (hit_ct)                run_d = cmd_run;
    else if (expire && !ctrl_q.cont) run_d = 1'b0;
    else                            run_d = run_q;

    if (expire)     to_d = 1'b1;
    else if (hit_st) to_d = 1'b0;
    else            to_d = to_q;

    cap_d = hit_cap ? count : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      to_q   <= 1'b0;
      ctrl_q <= '0;
      plo_q  <= '0;
      phi_q  <= '0;
      cap_q  <= '0;
    end else begin
      run_q <= run_d;
      to_q  <= to_d;
      if (hit_ct)  ctrl_q <= ctrl_d;
      if (hit_plo) plo_q  <= plo_d;
      if (hit_phi) phi_q  <= phi_d;
      if (hit_cap) cap_q  <= cap_d;
    end
  end

  assign run     = run_q;
  assign to_flag = to_q;
  assign ctrl    = ctrl_q;
  assign per_lo  = plo_q;
  assign per_hi  = phi_q;
  assign cap     = cap_q;

  p_per_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_plo || hit_phi) |=> !run_q);
  p_both_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ct && wdata[CT_GO] && wdata[CT_HALT]) |=> !run_q);
  p_to_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> to_q);
  p_to_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (to_q && !hit_st) |=> to_q);
  p_to_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_st && !expire) |=> !to_q);
  p_run_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_st && !expire) |=> (run_q == $past(run_q)));
endmodule

// File: rtl/intv_rdport.sv
`timescale 1ns/1ps
module intv_rdport
  import intv_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                run,
  input  logic                to_flag,
  input  ctrl_t               ctrl,
  input  logic [DATA_W/2-1:0] per_lo,
  input  logic [DATA_W/2-1:0] per_hi,
  input  logic [DATA_W-1:0]   cap,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] dat_d, dat_q;
  logic              vld_q;
  logic              unused_lo;

  assign idx       = addr[ADDR_W-1:2];
  assign unused_lo = ^addr[1:0];

  always_comb begin
    dat_d = '0;
    if (idx == IDX_W'(IX_STATUS)) begin
      dat_d[ST_TO]  = to_flag;
      dat_d[ST_RUN] = run;
    end else if (idx == IDX_W'(IX_CTRL)) begin
      dat_d[CT_IEN]  = ctrl.ien;
      dat_d[CT_CONT] = ctrl.cont;
    end else if (idx == IDX_W'(IX_PER_LO)) begin
      dat_d[HALF_W-1:0] = per_lo;
    end else if (idx == IDX_W'(IX_PER_HI)) begin
      dat_d[HALF_W-1:0] = per_hi;
    end else if (idx == IDX_W'(IX_CAP_LO)) begin
      dat_d[HALF_W-1:0] = cap[HALF_W-1:0];
    end else if (idx == IDX_W'(IX_CAP_HI)) begin
      dat_d[HALF_W-1:0] = cap[DATA_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) dat_q <= dat_d;
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = dat_q;

  p_rd_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_ctrl_cmd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == IDX_W'(IX_CTRL)) |=> (rd_data[DATA_W-1:2] == '0));
endmodule

// File: rtl/intv_timer.sv
`timescale 1ns/1ps
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int HALF_W = DATA_W / 2;

  logic              run, to_flag, per_load, expire;
  ctrl_t             ctrl;
  logic [HALF_W-1:0] per_lo, per_hi;
  logic [DATA_W-1:0] per_val, count, cap;

  intv_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
    .load(per_load), .load_val(per_val), .count(count), .expire(expire)
  );

  intv_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .count(count), .expire(expire), .run(run), .to_flag(to_flag),
    .ctrl(ctrl), .per_lo(per_lo), .per_hi(per_hi), .per_load(per_load),
    .per_val(per_val), .cap(cap)
  );

  intv_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .run(run),
    .to_flag(to_flag), .ctrl(ctrl), .per_lo(per_lo), .per_hi(per_hi),
    .cap(cap), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign irq = to_flag & ctrl.ien;
endmodule

// File: tb/intv_timer_test.sv
`timescale 1ns/1ps
module intv_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  intv_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read returns against the scoreboard
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected read data", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic capture_chk(input logic [31:0] exp, input string tag);
    wr(8'h10, 32'h0);
    rd(8'h10, {16'h0, exp[15:0]}, tag);
    rd(8'h14, {16'h0, exp[31:16]}, tag);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    check("R12 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, 32'h0, "R1 status");
    rd(8'h04, 32'h0, "R1 control");
    rd(8'h08, 32'h0, "R1 period lo");
    rd(8'h0C, 32'h0, "R1 period hi");
    rd(8'h10, 32'h0, "R1 capture lo");
    rd(8'h14, 32'h0, "R1 capture hi");
    check("R1 irq", {31'h0, irq}, 32'h0);
    capture_chk(32'hFFFF_FFFF, "R1 R8 count after reset");

    // R2 index decode
    rd(8'h18, 32'h0, "R2 unmapped read");
    wr(8'h05, 32'h3);
    rd(8'h04, 32'h3, "R2 low address bits ignored");
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h04, 32'h3, "R2 unmapped write ignored");
    rd(8'h00, 32'h0, "R2 unmapped write no start");

    // R3 control storage
    wr(8'h04, 32'hFFFF_FFF3);
    rd(8'h04, 32'h3, "R3 only bits 1:0 stored");
    // R4 start+stop together on a stopped timer
    wr(8'h04, 32'h0C);
    rd(8'h00, 32'h0, "R4 start+stop ends stopped");
    wr(8'h04, 32'h04);
    rd(8'h00, 32'h2, "R4 start runs");
    rd(8'h04, 32'h0, "R3 command bits read zero");
    wr(8'h04, 32'h04);
    rd(8'h00, 32'h2, "R4 start while running");
    wr(8'h04, 32'h08);
    rd(8'h00, 32'h0, "R4 stop halts");
    wr(8'h04, 32'h08);
    rd(8'h00, 32'h0, "R4 stop while stopped");

    // R5 period write stops and loads
    wr(8'h04, 32'h04);
    rd(8'h00, 32'h2, "R5 running before period write");
    wr(8'h08, 32'h0001_2345);
    rd(8'h00, 32'h0, "R5 period write stops");
    rd(8'h08, 32'h2345, "R5 period lo truncated");
    wr(8'h0C, 32'hABCD_0000);
    rd(8'h0C, 32'h0, "R5 period hi truncated");
    wr(8'h08, 32'h3);
    capture_chk(32'h3, "R5 R8 counter loaded");

    // R6 R7 one-shot with period 3
    wr(8'h04, 32'h05);
    ticks(3);
    rd(8'h00, 32'h2, "R6 no timeout after 3 ticks");
    capture_chk(32'h0, "R6 count at zero");
    repeat (10) @(negedge clk);
    rd(8'h00, 32'h2, "R6 idle cycles do not count");
    check("R10 irq low before timeout", {31'h0, irq}, 32'h0);
    ticks(1);
    rd(8'h00, 32'h1, "R6 R7 one-shot timeout stops");
    check("R10 irq high", {31'h0, irq}, 32'h1);
    capture_chk(32'h3, "R7 one-shot reloads period");

    // R9 R11 status writes
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R9 status write clears");
    check("R10 irq low after clear", {31'h0, irq}, 32'h0);
    wr(8'h00, 32'h2);
    rd(8'h00, 32'h0, "R11 run flag not writable");

    // R7 continuous
    wr(8'h04, 32'h07);
    ticks(4);
    rd(8'h00, 32'h3, "R7 continuous keeps running");
    check("R10 irq continuous", {31'h0, irq}, 32'h1);
    capture_chk(32'h3, "R7 continuous reload");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h2, "R11 R9 status write keeps run");
    ticks(4);
    rd(8'h00, 32'h3, "R7 second period");
    wr(8'h00, 32'h0);
    ticks(2);
    capture_chk(32'h1, "R6 mid-period count");
    rd(8'h00, 32'h2, "R6 no early timeout");

    // R10 interrupt enable gating
    wr(8'h04, 32'h02);
    ticks(2);
    rd(8'h00, 32'h3, "R10 timeout with irq disabled");
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    wr(8'h04, 32'h03);
    check("R10 irq after enable", {31'h0, irq}, 32'h1);

    // R9 timeout beats a status write in the same cycle
    wr(8'h04, 32'h0B);
    rd(8'h00, 32'h1, "R4 stop with flags");
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h07);
    rd(8'h00, 32'h2, "R9 setup running");
    tick_en = 1'b1; wr_en = 1'b1; addr = 8'h00; wdata = 32'h0;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(8'h00, 32'h3, "R9 timeout wins over clear");
    check("R10 irq after collision", {31'h0, irq}, 32'h1);

    finish_run();
  end
endmodule